// File: doc/BRIEF.md
# PLL Retune Sequencer

This block retunes an integer-N PLL to a new output frequency. It holds its own copy of the PLL control words and drives them straight to the analog macro. A parameter table lists the frequencies it supports. Each entry gives a rate in MHz, a multiplier M, a pre-divider N and a power-of-two post-divider OD. When a retune request names a rate that is in the table, the block runs a fixed sequence. It asserts the PLL reset, loads the new N with reset released, loads M, then loads OD. After that it watches the lock indication until the PLL locks or a poll budget runs out.

The block always reports the frequency implied by the fields currently programmed. It also answers a rounding query, which maps any requested rate onto a rate the table can deliver. A table whose first entry has rate zero counts as empty. In that case the block only reports the rate and refuses every retune request.

Top module: `pll_retune_ctrl`

## Requirements
- R1: `rate_mhz_o` equals (`ref_mhz_i` × M / N) >> OD, using integer MHz arithmetic, where M is control word 0 bits [8:0], N is word 0 bits [13:9] and OD is word 1 bits [17:16].
- R2: After reset the control words hold their initial values (word 0 = 0x232, ignoring bit 31; word 1 = 0x0001A5A5), and `busy_o`, `done_o` and `err_o` are low.
- R3: The table ends at the first entry whose rate is zero. Entries after it are never matched by a retune request and never returned by the rounding query.
- R4: `round_mhz_o` returns the first live table rate, in table order, that is greater than or equal to `round_req_i`. If no live rate qualifies, it returns the rate of entry 0.
- R5: A request whose rate equals a live entry is accepted. When the PLL locks, `done_o` pulses with `err_o` low and `rate_mhz_o` equals the requested rate.
- R6: A request with a zero requested rate, a zero `ref_mhz_i`, or no exact table match is rejected. `done_o` and `err_o` pulse in the cycle after the request, `busy_o` stays low and the control words are unchanged.
- R7: After an accepted request, the reset bit (word 0 bit 29) rises one cycle after acceptance. The next cycle loads N and clears reset, the cycle after that loads M, and the cycle after that loads OD. Lock polling then starts.
- R8: Every field write is a read-modify-write. All bits of a control word outside the field being written keep their value.
- R9: If word 0 bit 31 (the registered lock input) is never seen high within LOCK_POLLS polls, the sequence ends with `done_o` and `err_o` together. This happens LOCK_POLLS+4 cycles after the acceptance edge.
- R10: `busy_o` is high from acceptance until the sequence ends. Requests that arrive while it is high are ignored.
- R11: With an empty table the block refuses every request with `err_o` and never goes busy, while `rate_mhz_o` still reports the programmed rate.
- R12: `done_o` and `err_o` are single-cycle pulses, and `err_o` is high only together with `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| ref_mhz_i | input | 16 | Reference frequency in MHz |
| set_valid_i | input | 1 | Retune request strobe |
| set_mhz_i | input | 16 | Requested output rate in MHz |
| round_req_i | input | 16 | Rate to round to a supported one |
| round_mhz_o | output | 16 | Rounded supported rate |
| rate_mhz_o | output | 16 | Rate implied by the programmed fields |
| busy_o | output | 1 | Retune sequence in progress |
| done_o | output | 1 | Sequence end pulse |
| err_o | output | 1 | Rejection or lock timeout, with done |
| pll_lock_i | input | 1 | Lock indication from the PLL |
| pll_ctrl_o | output | NUM_REGS*32 | PLL control words, word 0 in the low bits |

## Verification
Retune requests are driven in three groups. Exact matches whose entries differ in all three fields show that every field reaches the PLL. Near-miss rates show that only exact matches are accepted. A rate placed after the zero terminator shows that the table ends there. Zero rate and zero reference requests cover the rejection paths, which complete in one cycle without going busy. A cycle-by-cycle trace of one retune checks the order of reset, N, M and OD. Running the lock model with lock held off checks the exact timeout latency. Rounding queries below, between, on and above the table rates show whether the search keeps table order and falls back to entry 0.

// File: rtl/pll_retune_pkg.sv
package pll_retune_pkg;

    localparam int unsigned WORD_W = 32;
    localparam int unsigned MHZ_W  = 16;

    typedef struct packed {
        logic [MHZ_W-1:0] rate;
        logic [15:0]      m;
        logic [15:0]      n;
        logic [7:0]       od;
    } pll_entry_t;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_RESET,
        SQ_WR_N,
        SQ_WR_M,
        SQ_WR_OD,
        SQ_POLL
    } seq_state_e;

    function automatic logic [WORD_W-1:0] field_mask(int unsigned sh, int unsigned wd);
        return ((WORD_W'(1) << wd) - WORD_W'(1)) << sh;
    endfunction

    function automatic logic [WORD_W-1:0] get_field(logic [WORD_W-1:0] w,
                                                    int unsigned sh, int unsigned wd);
        return (w & field_mask(sh, wd)) >> sh;
    endfunction

    function automatic logic [WORD_W-1:0] put_field(logic [WORD_W-1:0] w,
                                                    int unsigned sh, int unsigned wd,
                                                    logic [WORD_W-1:0] v);
        return (w & ~field_mask(sh, wd)) | ((v << sh) & field_mask(sh, wd));
    endfunction

endpackage

// File: rtl/pll_table_search.sv
module pll_table_search
    import pll_retune_pkg::*;
#(
    parameter int unsigned NUM_ENTRIES = 5,
    parameter pll_entry_t  TABLE [NUM_ENTRIES] = '{default: '0}
) (
    input  logic [MHZ_W-1:0] set_mhz_i,
    input  logic [MHZ_W-1:0] round_req_i,
    output logic             hit_o,
    output pll_entry_t       hit_entry_o,
    output logic [MHZ_W-1:0] round_mhz_o,
    output logic             empty_o
);

    logic [NUM_ENTRIES-1:0] nonzero;
    logic [NUM_ENTRIES-1:0] live;

    // An entry is live only while every entry up to it has a non-zero rate.
    for (genvar gi = 0; gi < NUM_ENTRIES; gi++) begin : g_live
        assign nonzero[gi] = (TABLE[gi].rate != '0);
        assign live[gi]    = &nonzero[gi:0];
    end

    always_comb begin
        logic found;
        hit_o       = 1'b0;
        hit_entry_o = '0;
        found       = 1'b0;
        round_mhz_o = TABLE[0].rate;
        for (int i = 0; i < NUM_ENTRIES; i++) begin
            if (!hit_o && live[i] && (TABLE[i].rate == set_mhz_i)) begin
                hit_o       = 1'b1;
                hit_entry_o = TABLE[i];
            end
            if (!found && live[i] && (TABLE[i].rate >= round_req_i)) begin
                found       = 1'b1;
                round_mhz_o = TABLE[i].rate;
            end
        end
    end

    assign empty_o = ~live[0];

endmodule

// File: rtl/pll_rate_calc.sv
module pll_rate_calc
    import pll_retune_pkg::*;
#(
    parameter int unsigned NUM_REGS = 2,
    parameter int unsigned N_REG    = 0,
    parameter int unsigned N_SHIFT  = 9,
    parameter int unsigned N_W      = 5,
    parameter int unsigned M_REG    = 0,
    parameter int unsigned M_SHIFT  = 0,
    parameter int unsigned M_W      = 9,
    parameter int unsigned OD_REG   = 1,
    parameter int unsigned OD_SHIFT = 16,
    parameter int unsigned OD_W     = 2
) (
    input  logic [NUM_REGS-1:0][WORD_W-1:0] regs_i,
    input  logic [MHZ_W-1:0]                ref_mhz_i,
    output logic [MHZ_W-1:0]                rate_mhz_o
);

    logic [WORD_W-1:0] n_v, m_v, od_v, prod, quo, shifted;

    always_comb begin
        n_v     = get_field(regs_i[N_REG], N_SHIFT, N_W);
        m_v     = get_field(regs_i[M_REG], M_SHIFT, M_W);
        od_v    = get_field(regs_i[OD_REG], OD_SHIFT, OD_W);
        prod    = {{(WORD_W-MHZ_W){1'b0}}, ref_mhz_i} * m_v;
        quo     = (n_v == '0) ? '0 : prod / n_v;
        shifted = quo >> od_v;
    end

    assign rate_mhz_o = shifted[MHZ_W-1:0];

endmodule

// File: rtl/pll_retune_ctrl.sv
module pll_retune_ctrl
    import pll_retune_pkg::*;
#(
    parameter int unsigned NUM_REGS    = 2,
    parameter int unsigned NUM_ENTRIES = 5,
    parameter pll_entry_t  TABLE [NUM_ENTRIES] = '{
        '{16'd408,  16'd68,  16'd1, 8'd2},
        '{16'd792,  16'd66,  16'd1, 8'd1},
        '{16'd1200, 16'd100, 16'd2, 8'd0},
        '{16'd0,    16'd0,   16'd0, 8'd0},
        '{16'd1500, 16'd125, 16'd2, 8'd0}
    },
    parameter int unsigned LOCK_POLLS  = 24_000_000,
    parameter int unsigned N_REG       = 0,
    parameter int unsigned N_SHIFT     = 9,
    parameter int unsigned N_W         = 5,
    parameter int unsigned M_REG       = 0,
    parameter int unsigned M_SHIFT     = 0,
    parameter int unsigned M_W         = 9,
    parameter int unsigned OD_REG      = 1,
    parameter int unsigned OD_SHIFT    = 16,
    parameter int unsigned OD_W        = 2,
    parameter int unsigned RST_BIT     = 29,
    parameter int unsigned LOCK_BIT    = 31,
    parameter logic [NUM_REGS*32-1:0] REG_INIT = {32'h0001_A5A5, 32'h0000_0232}
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic [15:0]              ref_mhz_i,
    input  logic                     set_valid_i,
    input  logic [15:0]              set_mhz_i,
    input  logic [15:0]              round_req_i,
    output logic [15:0]              round_mhz_o,
    output logic [15:0]              rate_mhz_o,
    output logic                     busy_o,
    output logic                     done_o,
    output logic                     err_o,
    input  logic                     pll_lock_i,
    output logic [NUM_REGS*32-1:0]   pll_ctrl_o
);

    localparam int unsigned CNT_W = $clog2(LOCK_POLLS + 1);

    typedef struct packed {
        seq_state_e                     state;
        logic [NUM_REGS-1:0][WORD_W-1:0] regs;
        pll_entry_t                     tgt;
        logic [CNT_W-1:0]               polls;
        logic                           done;
        logic                           err;
    } ctrl_t;

    ctrl_t      ctrl_d, ctrl_q;
    logic       hit;
    pll_entry_t hit_entry;
    logic       table_empty;

    pll_table_search #(
        .NUM_ENTRIES (NUM_ENTRIES),
        .TABLE       (TABLE)
    ) i_search (
        .set_mhz_i   (set_mhz_i),
        .round_req_i (round_req_i),
        .hit_o       (hit),
        .hit_entry_o (hit_entry),
        .round_mhz_o (round_mhz_o),
        .empty_o     (table_empty)
    );

    pll_rate_calc #(
        .NUM_REGS (NUM_REGS),
        .N_REG    (N_REG),    .N_SHIFT  (N_SHIFT),  .N_W  (N_W),
        .M_REG    (M_REG),    .M_SHIFT  (M_SHIFT),  .M_W  (M_W),
        .OD_REG   (OD_REG),   .OD_SHIFT (OD_SHIFT), .OD_W (OD_W)
    ) i_rate (
        .regs_i     (ctrl_q.regs),
        .ref_mhz_i  (ref_mhz_i),
        .rate_mhz_o (rate_mhz_o)
    );

    always_comb begin
        ctrl_d      = ctrl_q;
        ctrl_d.done = 1'b0;
        ctrl_d.err  = 1'b0;
        // The lock status bit mirrors the PLL every cycle.
        ctrl_d.regs[N_REG][LOCK_BIT] = pll_lock_i;
        unique case (ctrl_q.state)
            SQ_IDLE: begin
                if (set_valid_i) begin
                    if ((ref_mhz_i == '0) || (set_mhz_i == '0) || !hit) begin
                        ctrl_d.done = 1'b1;
                        ctrl_d.err  = 1'b1;
                    end else begin
                        ctrl_d.tgt   = hit_entry;
                        ctrl_d.state = SQ_RESET;
                    end
                end
            end
            SQ_RESET: begin
                ctrl_d.regs[N_REG][RST_BIT] = 1'b1;
                ctrl_d.state = SQ_WR_N;
            end
            SQ_WR_N: begin
                ctrl_d.regs[N_REG] = put_field(ctrl_d.regs[N_REG], N_SHIFT, N_W,
                                               {16'h0, ctrl_q.tgt.n});
                ctrl_d.regs[N_REG][RST_BIT] = 1'b0;
                ctrl_d.state = SQ_WR_M;
            end
            SQ_WR_M: begin
                ctrl_d.regs[M_REG] = put_field(ctrl_d.regs[M_REG], M_SHIFT, M_W,
                                               {16'h0, ctrl_q.tgt.m});
                ctrl_d.state = SQ_WR_OD;
            end
            SQ_WR_OD: begin
                ctrl_d.regs[OD_REG] = put_field(ctrl_d.regs[OD_REG], OD_SHIFT, OD_W,
                                                {24'h0, ctrl_q.tgt.od});
                ctrl_d.polls = '0;
                ctrl_d.state = SQ_POLL;
            end
            SQ_POLL: begin
                if (ctrl_q.regs[N_REG][LOCK_BIT]) begin
                    ctrl_d.done  = 1'b1;
                    ctrl_d.state = SQ_IDLE;
                end else if (ctrl_q.polls == CNT_W'(LOCK_POLLS - 1)) begin
                    ctrl_d.done  = 1'b1;
                    ctrl_d.err   = 1'b1;
                    ctrl_d.state = SQ_IDLE;
                end else begin
                    ctrl_d.polls = ctrl_q.polls + 1'b1;
                end
            end
            default: ctrl_d.state = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            ctrl_q.state <= SQ_IDLE;
            ctrl_q.regs  <= REG_INIT;
            ctrl_q.tgt   <= '0;
            ctrl_q.polls <= '0;
            ctrl_q.done  <= 1'b0;
            ctrl_q.err   <= 1'b0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign busy_o     = (ctrl_q.state != SQ_IDLE);
    assign done_o     = ctrl_q.done;
    assign err_o      = ctrl_q.err;
    assign pll_ctrl_o = ctrl_q.regs;

    // R10
    busy_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(busy_o) |-> done_o);

    // R12
    err_with_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_o |-> done_o);

    // R7
    poll_rst_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ctrl_q.state == SQ_POLL) |-> !pll_ctrl_o[N_REG*32 + RST_BIT]);

    // R9
    poll_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_o |-> (ctrl_q.polls < CNT_W'(LOCK_POLLS)));

    // R11
    ro_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        table_empty |-> !busy_o);

    // R5
    lock_seen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($fell(busy_o) && !err_o) |-> $past(pll_ctrl_o[N_REG*32 + LOCK_BIT]));

endmodule

// File: tb/test_pll_retune_ctrl.sv
`timescale 1ns/1ps
module test_pll_retune_ctrl;
    import pll_retune_pkg::*;

    localparam int unsigned POLLS = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] ref_mhz = 16'd24;
    logic        set_valid = 1'b0;
    logic [15:0] set_mhz = '0;
    logic [15:0] round_req = '0;
    logic [15:0] round_mhz, rate_mhz;
    logic        busy, done, err, lock;
    logic [63:0] ctrl;

    logic        ro_valid = 1'b0;
    logic [15:0] ro_round, ro_rate;
    logic        ro_busy, ro_done, ro_err;
    logic [63:0] ro_ctrl;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    // Behavioural lock model: lock drops while reset is set, returns after lock_dly cycles.
    bit lock_en = 1'b1;
    int lock_dly = 3;
    int lk_cnt = 0;
    always @(posedge clk) begin
        if (!rst_n || ctrl[29]) lk_cnt <= 0;
        else if (lk_cnt < 1000) lk_cnt <= lk_cnt + 1;
    end
    assign lock = lock_en && (lk_cnt >= lock_dly);

    pll_retune_ctrl #(.LOCK_POLLS(POLLS)) i_pll_retune_ctrl (
        .clk_i(clk), .rst_ni(rst_n), .ref_mhz_i(ref_mhz),
        .set_valid_i(set_valid), .set_mhz_i(set_mhz),
        .round_req_i(round_req), .round_mhz_o(round_mhz), .rate_mhz_o(rate_mhz),
        .busy_o(busy), .done_o(done), .err_o(err),
        .pll_lock_i(lock), .pll_ctrl_o(ctrl)
    );

    pll_retune_ctrl #(.LOCK_POLLS(POLLS), .TABLE('{default: '0})) i_pll_retune_ctrl_ro (
        .clk_i(clk), .rst_ni(rst_n), .ref_mhz_i(ref_mhz),
        .set_valid_i(ro_valid), .set_mhz_i(16'd792),
        .round_req_i(16'd500), .round_mhz_o(ro_round), .rate_mhz_o(ro_rate),
        .busy_o(ro_busy), .done_o(ro_done), .err_o(ro_err),
        .pll_lock_i(1'b0), .pll_ctrl_o(ro_ctrl)
    );

    typedef struct packed {
        logic [15:0] req;
        logic [15:0] refm;
        logic        fail;
        logic [15:0] rate;
    } vec_t;

    localparam vec_t VECS [7] = '{
        '{16'd792,  16'd24, 1'b0, 16'd792},   // R5 exact match
        '{16'd1200, 16'd24, 1'b0, 16'd1200},  // R5 exact match, N=2
        '{16'd500,  16'd24, 1'b1, 16'd1200},  // R6 no match
        '{16'd1500, 16'd24, 1'b1, 16'd1200},  // R3 entry beyond terminator
        '{16'd0,    16'd24, 1'b1, 16'd1200},  // R6 zero rate
        '{16'd408,  16'd24, 1'b0, 16'd408},   // R5 exact match, OD=2
        '{16'd792,  16'd0,  1'b1, 16'd0}      // R6 zero reference
    };

    function automatic int fld_m(logic [63:0] c);  return int'(c[8:0]);   endfunction
    function automatic int fld_n(logic [63:0] c);  return int'(c[13:9]);  endfunction
    function automatic int fld_od(logic [63:0] c); return int'(c[49:48]); endfunction

    task automatic chk(input string rq, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    task automatic run_set(input logic [15:0] r, output int lat, output logic e, output logic b1);
        @(negedge clk);
        set_valid = 1'b1;
        set_mhz   = r;
        @(posedge clk); #1;
        set_valid = 1'b0;
        lat = 1;
        b1  = busy;
        while (!done && lat < 500) begin
            @(posedge clk); #1;
            lat++;
        end
        e = err;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=finished");
        summary();
    end

    initial begin
        int lat;
        logic e, b1;
        int dones;

        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        @(posedge clk); #1;

        // R2 reset state
        chk("R2 word0", int'(ctrl[30:0]), 32'h232);
        chk("R2 word1", int'(ctrl[63:32]), 32'h0001A5A5);
        chk("R2 busy", int'(busy), 0);
        chk("R2 done", int'(done), 0);
        chk("R2 err", int'(err), 0);
        // R1 readback of initial fields: 24*50/1 >> 1
        chk("R1 readback init", int'(rate_mhz), 600);

        // R4 / R3 rounding queries
        round_req = 16'd300;  #1; chk("R4 round below", int'(round_mhz), 408);
        round_req = 16'd500;  #1; chk("R4 round between", int'(round_mhz), 792);
        round_req = 16'd792;  #1; chk("R4 round equal", int'(round_mhz), 792);
        round_req = 16'd0;    #1; chk("R4 round zero", int'(round_mhz), 408);
        round_req = 16'd1300; #1; chk("R3 round past terminator", int'(round_mhz), 408);

        // Vector walk: R5, R6, R3, R8, R12
        foreach (VECS[i]) begin
            ref_mhz = VECS[i].refm;
            run_set(VECS[i].req, lat, e, b1);
            chk(VECS[i].fail ? "R6 err" : "R5 err", int'(e), int'(VECS[i].fail));
            chk("R1 readback", int'(rate_mhz), int'(VECS[i].rate));
            if (VECS[i].fail) begin
                chk("R6 latency", lat, 1);
                chk("R6 no busy", int'(b1), 0);
            end else begin
                chk("R10 busy at accept", int'(b1), 1);
            end
            chk("R8 word1 kept", int'(ctrl[63:32] & 32'hFFFC_FFFF), 32'h0000A5A5);
            chk("R8 word0 kept", int'(ctrl[30:14]), 0);
            @(posedge clk); #1;
            chk("R12 done pulse", int'(done), 0);
        end
        ref_mhz = 16'd24;

        // R7 ordering: 408 (m68 n1 od2) -> 1200 (m100 n2 od0)
        @(negedge clk); set_valid = 1'b1; set_mhz = 16'd1200;
        @(posedge clk); #1; set_valid = 1'b0;
        chk("R7 c1 rst", int'(ctrl[29]), 0);
        @(posedge clk); #1;
        chk("R7 c2 rst", int'(ctrl[29]), 1);
        chk("R7 c2 n old", fld_n(ctrl), 1);
        @(posedge clk); #1;
        chk("R7 c3 rst", int'(ctrl[29]), 0);
        chk("R7 c3 n new", fld_n(ctrl), 2);
        chk("R7 c3 m old", fld_m(ctrl), 68);
        @(posedge clk); #1;
        chk("R7 c4 m new", fld_m(ctrl), 100);
        chk("R7 c4 od old", fld_od(ctrl), 2);
        @(posedge clk); #1;
        chk("R7 c5 od new", fld_od(ctrl), 0);
        lat = 0;
        while (!done && lat < 500) begin @(posedge clk); #1; lat++; end
        chk("R5 err after lock", int'(err), 0);
        chk("R5 readback", int'(rate_mhz), 1200);

        // R10 requests while busy are ignored
        dones = 0;
        @(negedge clk); set_valid = 1'b1; set_mhz = 16'd792;
        @(negedge clk); set_valid = 1'b0;
        @(negedge clk); set_valid = 1'b1; set_mhz = 16'd408;
        @(negedge clk); set_valid = 1'b0;
        chk("R10 busy mid", int'(busy), 1);
        for (int k = 0; k < 60; k++) begin
            @(posedge clk); #1;
            if (done) dones++;
        end
        chk("R10 one done", dones, 1);
        chk("R10 readback", int'(rate_mhz), 792);

        // R9 timeout with lock withheld
        lock_en = 1'b0;
        run_set(16'd408, lat, e, b1);
        chk("R9 err", int'(e), 1);
        chk("R9 latency", lat, POLLS + 5);
        chk("R9 fields written", int'(rate_mhz), 408);
        @(posedge clk); #1;
        chk("R12 err pulse", int'(err), 0);
        lock_en = 1'b1;

        // R11 empty table
        chk("R11 ro readback", int'(ro_rate), 600);
        @(negedge clk); ro_valid = 1'b1;
        @(posedge clk); #1; ro_valid = 1'b0;
        chk("R11 ro err", int'(ro_err), 1);
        chk("R11 ro done", int'(ro_done), 1);
        chk("R11 ro busy", int'(ro_busy), 0);
        @(posedge clk); #1;
        chk("R11 ro still idle", int'(ro_busy), 0);
        chk("R11 ro word0", int'(ro_ctrl[30:0]), 32'h232);

        summary();
    end

endmodule